// File: doc/BRIEF.md
# Indirect Configuration Access Bridge

The bridge gives a host an address/data register pair through which it reaches the configuration space of attached device functions. The host first writes a 32-bit selector into the address port. Bit 31 of the selector enables the data window. Bits 23:16 name the bus, bits 15:8 the device/function number, and the low bits give the register offset. Accesses of 1, 2 or 4 bytes through the data port then become single-cycle configuration requests on the downstream side. Read data comes back to the host one cycle later.

Before forwarding an access, the bridge filters it. It checks the enable bit, the access length and the presence of the target function. A non-zero function that was hot-added while function 0 of the same device is missing is also treated as absent. The transfer length is cut so that it never crosses the end of the 256-byte space. A rejected write has no effect, and a rejected read returns all ones. A parameter sets the host byte ordering to little-endian or big-endian.

Top module: `cfg_access_bridge`

## Requirements
- R1: The address port is written only by a 4-byte write at port offset 0. A write to it with any other offset or length leaves the stored selector unchanged.
- R2: A read of the address port returns the whole stored 32-bit selector, whatever the offset and length.
- R3: While selector bit 31 is 0, data-port writes raise no downstream request, and data-port reads raise none and return 0xFFFFFFFF.
- R4: The effective address is the selector ORed with data-port offset bits 1:0. The request carries bus = bits 23:16, devfn = bits 15:8 and register offset = bits 7:0 of it.
- R5: When no function is present at the selected bus/devfn, a write is dropped and a read returns 0xFFFFFFFF. A bus number at or above the parameterised bus count counts as absent.
- R6: A function with a non-zero function number (devfn bits 2:0) that is flagged hot-added while function 0 of its device is absent is hidden, as in R5. If it is not flagged hot-added, the same function stays visible.
- R7: The downstream length equals the smaller of the requested length and the bytes left before offset 256.
- R8: Every host read gets the read-valid strobe in the cycle after the request. Writes never get it.
- R9: A data-port access whose length is not 1, 2 or 4 raises no request. If it is a read, it returns 0xFFFFFFFF.
- R10: Data from a forwarded read is right-aligned and zero above the transferred bytes. Write data sent downstream is zero above the transferred bytes.
- R11: With big-endian host ordering, the bytes of the address port are reversed in both directions, and so are the bytes within each data transfer.
- R12: Reset clears the selector to 0, which disables the data window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_valid_i | input | 1 | Host access strobe, one cycle |
| host_write_i | input | 1 | 1 = write, 0 = read |
| host_sel_i | input | 1 | 0 = address port, 1 = data port |
| host_off_i | input | 2 | Byte offset within the port |
| host_len_i | input | 3 | Access length in bytes |
| host_wdata_i | input | 32 | Host write data, right-aligned |
| host_rvalid_o | output | 1 | Read data valid, one cycle after a read |
| host_rdata_o | output | 32 | Read data |
| cfg_req_o | output | 1 | Downstream configuration request |
| cfg_write_o | output | 1 | Request direction |
| cfg_bus_o | output | 8 | Bus number |
| cfg_devfn_o | output | 8 | Device/function number |
| cfg_off_o | output | OFF_W | Register offset |
| cfg_len_o | output | 3 | Transfer length in bytes |
| cfg_wdata_o | output | 32 | Write data, zero above the transfer |
| cfg_rdata_i | input | 32 | Read data from the target, same cycle |
| dev_present_i | input | NUM_BUS*256 | Presence flag per bus/devfn |
| dev_hotplug_i | input | NUM_BUS*256 | Hot-added flag per bus/devfn |

## Verification
In one data-port access, the OR of the port offset into the selector and the length clamp at the end of the space can both apply. With a selector offset of 0xFD and a port offset of 2, the effective offset becomes 0xFF, and a 4-byte read must leave as a 1-byte request. The bench judges such cases by the offset and length seen on the request port and by the zero-extended data returned. A second bridge instance with big-endian ordering covers the case where byte reversal and length-based masking meet in one transfer.

// File: rtl/cab_pkg.sv
package cab_pkg;

  typedef enum logic {
    PORT_ADDR = 1'b0,
    PORT_DATA = 1'b1
  } port_e;

  function automatic logic [31:0] len_mask(logic [2:0] len);
    case (len)
      3'd1:    return 32'h0000_00ff;
      3'd2:    return 32'h0000_ffff;
      3'd3:    return 32'h00ff_ffff;
      default: return 32'hffff_ffff;
    endcase
  endfunction

  // reverse byte order within the low len bytes
  function automatic logic [31:0] byte_rev(logic [31:0] d, logic [2:0] len);
    case (len)
      3'd1:    return {24'h0, d[7:0]};
      3'd2:    return {16'h0, d[7:0], d[15:8]};
      3'd3:    return {8'h0, d[7:0], d[15:8], d[23:16]};
      default: return {d[7:0], d[15:8], d[23:16], d[31:24]};
    endcase
  endfunction

  function automatic logic len_legal(logic [2:0] len);
    return (len == 3'd1) || (len == 3'd2) || (len == 3'd4);
  endfunction

endpackage

// File: rtl/cab_sel_reg.sv
module cab_sel_reg (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= '0;
    else if (wr_en_i) q_o <= wdata_i;
  end
endmodule

// File: rtl/cab_decode.sv
module cab_decode #(
  parameter int CFG_BYTES = 256,
  localparam int OFF_W = $clog2(CFG_BYTES)
) (
  input  logic [31:0]      sel_i,
  input  logic [1:0]       port_off_i,
  input  logic [2:0]       len_i,
  output logic             enable_o,
  output logic [7:0]       bus_o,
  output logic [7:0]       devfn_o,
  output logic [OFF_W-1:0] off_o,
  output logic [2:0]       xfer_len_o
);
  logic [31:0]  eff;
  logic [OFF_W:0] remaining;
  logic [OFF_W:0] len_ext;
  logic         unused_hi;

  assign eff       = sel_i | {30'h0, port_off_i};
  assign enable_o  = eff[31];
  assign bus_o     = eff[23:16];
  assign devfn_o   = eff[15:8];
  assign off_o     = eff[OFF_W-1:0];
  assign unused_hi = ^eff[30:24];

  assign remaining = (OFF_W+1)'(CFG_BYTES) - {1'b0, off_o};
  assign len_ext   = {{(OFF_W-2){1'b0}}, len_i};

  always_comb begin
    if (len_ext > remaining) xfer_len_o = remaining[2:0];
    else                     xfer_len_o = len_i;
  end
endmodule

// File: rtl/cab_presence.sv
module cab_presence #(
  parameter int NUM_BUS = 2,
  localparam int PRES_W = NUM_BUS * 256,
  localparam int IDX_W  = $clog2(PRES_W)
) (
  input  logic [PRES_W-1:0] present_i,
  input  logic [PRES_W-1:0] hotplug_i,
  input  logic [7:0]        bus_i,
  input  logic [7:0]        devfn_i,
  output logic              visible_o
);
  logic             in_range;
  logic [IDX_W-1:0] idx_fn;
  logic [IDX_W-1:0] idx_f0;
  logic             fn_present;
  logic             f0_present;
  logic             orphan;

  assign in_range = int'(bus_i) < NUM_BUS;
  assign idx_fn   = IDX_W'({bus_i, devfn_i});
  assign idx_f0   = IDX_W'({bus_i, devfn_i[7:3], 3'b000});

  always_comb begin
    fn_present = 1'b0;
    f0_present = 1'b0;
    orphan     = 1'b0;
    if (in_range) begin
      fn_present = present_i[idx_fn];
      f0_present = present_i[idx_f0];
      orphan     = hotplug_i[idx_fn] && (devfn_i[2:0] != 3'd0) && !f0_present;
    end
  end

  assign visible_o = fn_present && !orphan;
endmodule

// File: rtl/cfg_access_bridge.sv
module cfg_access_bridge
  import cab_pkg::*;
#(
  parameter int NUM_BUS    = 2,
  parameter int CFG_BYTES  = 256,
  parameter bit BIG_ENDIAN = 1'b0,
  localparam int OFF_W  = $clog2(CFG_BYTES),
  localparam int PRES_W = NUM_BUS * 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_valid_i,
  input  logic              host_write_i,
  input  logic              host_sel_i,
  input  logic [1:0]        host_off_i,
  input  logic [2:0]        host_len_i,
  input  logic [31:0]       host_wdata_i,
  output logic              host_rvalid_o,
  output logic [31:0]       host_rdata_o,
  output logic              cfg_req_o,
  output logic              cfg_write_o,
  output logic [7:0]        cfg_bus_o,
  output logic [7:0]        cfg_devfn_o,
  output logic [OFF_W-1:0]  cfg_off_o,
  output logic [2:0]        cfg_len_o,
  output logic [31:0]       cfg_wdata_o,
  input  logic [31:0]       cfg_rdata_i,
  input  logic [PRES_W-1:0] dev_present_i,
  input  logic [PRES_W-1:0] dev_hotplug_i
);
  port_e       port;
  logic        sel_wr;
  logic [31:0] sel_wdata;
  logic [31:0] sel_q;
  logic [31:0] sel_rd;
  logic        enable;
  logic        visible;
  logic [2:0]  xfer_len;
  logic        data_acc;
  logic        fwd;
  logic [31:0] wdata_host;
  logic [31:0] rdata_dev;
  logic [31:0] rdata_host;
  logic [31:0] rdata_nxt;

  assign port   = port_e'(host_sel_i);
  assign sel_wr = host_valid_i && host_write_i && (port == PORT_ADDR) &&
                  (host_off_i == 2'd0) && (host_len_i == 3'd4);

  assign rdata_dev = cfg_rdata_i & len_mask(xfer_len);

  generate
    if (BIG_ENDIAN) begin : g_be
      assign sel_wdata  = byte_rev(host_wdata_i, 3'd4);
      assign sel_rd     = byte_rev(sel_q, 3'd4);
      assign wdata_host = byte_rev(host_wdata_i, host_len_i);
      assign rdata_host = byte_rev(rdata_dev, xfer_len);
    end else begin : g_le
      assign sel_wdata  = host_wdata_i;
      assign sel_rd     = sel_q;
      assign wdata_host = host_wdata_i;
      assign rdata_host = rdata_dev;
    end
  endgenerate

  cab_sel_reg u_sel (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (sel_wr),
    .wdata_i (sel_wdata),
    .q_o     (sel_q)
  );

  cab_decode #(.CFG_BYTES(CFG_BYTES)) u_dec (
    .sel_i      (sel_q),
    .port_off_i (host_off_i),
    .len_i      (host_len_i),
    .enable_o   (enable),
    .bus_o      (cfg_bus_o),
    .devfn_o    (cfg_devfn_o),
    .off_o      (cfg_off_o),
    .xfer_len_o (xfer_len)
  );

  cab_presence #(.NUM_BUS(NUM_BUS)) u_pres (
    .present_i (dev_present_i),
    .hotplug_i (dev_hotplug_i),
    .bus_i     (cfg_bus_o),
    .devfn_i   (cfg_devfn_o),
    .visible_o (visible)
  );

  assign data_acc    = host_valid_i && (port == PORT_DATA);
  assign fwd         = data_acc && enable && len_legal(host_len_i) && visible;
  assign cfg_req_o   = fwd;
  assign cfg_write_o = host_write_i;
  assign cfg_len_o   = xfer_len;
  assign cfg_wdata_o = wdata_host & len_mask(xfer_len);

  always_comb begin
    if (port == PORT_ADDR) rdata_nxt = sel_rd;
    else if (fwd)          rdata_nxt = rdata_host;
    else                   rdata_nxt = 32'hffff_ffff;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      host_rvalid_o <= 1'b0;
      host_rdata_o  <= '0;
    end else begin
      host_rvalid_o <= host_valid_i && !host_write_i;
      if (host_valid_i && !host_write_i) host_rdata_o <= rdata_nxt;
    end
  end

  AST_SEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(host_valid_i && host_write_i && !host_sel_i && host_off_i == 2'd0 && host_len_i == 3'd4)
    |=> $stable(sel_q)); // R1
  AST_REQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_o |-> sel_q[31]); // R3
  AST_LEN_IN_SPACE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_o |-> (cfg_len_o != 3'd0 && cfg_len_o <= 3'd4 &&
                   32'(cfg_off_o) + 32'(cfg_len_o) <= CFG_BYTES)); // R7
  AST_RD_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_valid_i && !host_write_i) |=> host_rvalid_o); // R8
  AST_WR_NO_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_valid_i && host_write_i) |=> !host_rvalid_o); // R8
  AST_BAD_LEN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_valid_i && host_sel_i && !(host_len_i inside {3'd1, 3'd2, 3'd4})) |-> !cfg_req_o); // R9

endmodule

// File: tb/tb_cfg_access_bridge.sv
module tb_cfg_access_bridge;

  localparam int NUM_BUS = 2;
  localparam int PRES_W  = NUM_BUS * 256;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        h_valid = 1'b0, h_write = 1'b0, h_sel = 1'b0;
  logic [1:0]  h_off = '0;
  logic [2:0]  h_len = '0;
  logic [31:0] h_wdata = '0;
  logic [PRES_W-1:0] present, hotplug;

  logic        rvalid, req, cwr;
  logic [31:0] rdata, cwdata, crdata;
  logic [7:0]  cbus, cdevfn, coff;
  logic [2:0]  clen;

  logic        rvalid_b, req_b, cwr_b;
  logic [31:0] rdata_b, cwdata_b, crdata_b;
  logic [7:0]  cbus_b, cdevfn_b, coff_b;
  logic [2:0]  clen_b;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  function automatic logic [31:0] model(logic [7:0] b, logic [7:0] df, logic [7:0] o);
    return {o + 8'd3, o + 8'd2, o + 8'd1, o} ^ {4{df ^ b}};
  endfunction

  function automatic logic [31:0] msk(logic [2:0] l);
    return (l == 3'd1) ? 32'hff : (l == 3'd2) ? 32'hffff : (l == 3'd3) ? 32'hffffff : 32'hffffffff;
  endfunction

  assign crdata   = model(cbus, cdevfn, coff);
  assign crdata_b = model(cbus_b, cdevfn_b, coff_b);

  cfg_access_bridge #(.NUM_BUS(NUM_BUS)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .host_valid_i(h_valid), .host_write_i(h_write),
    .host_sel_i(h_sel), .host_off_i(h_off), .host_len_i(h_len), .host_wdata_i(h_wdata),
    .host_rvalid_o(rvalid), .host_rdata_o(rdata), .cfg_req_o(req), .cfg_write_o(cwr),
    .cfg_bus_o(cbus), .cfg_devfn_o(cdevfn), .cfg_off_o(coff), .cfg_len_o(clen),
    .cfg_wdata_o(cwdata), .cfg_rdata_i(crdata), .dev_present_i(present),
    .dev_hotplug_i(hotplug));

  cfg_access_bridge #(.NUM_BUS(NUM_BUS), .BIG_ENDIAN(1'b1)) dut_be (
    .clk_i(clk), .rst_ni(rst_ni), .host_valid_i(h_valid), .host_write_i(h_write),
    .host_sel_i(h_sel), .host_off_i(h_off), .host_len_i(h_len), .host_wdata_i(h_wdata),
    .host_rvalid_o(rvalid_b), .host_rdata_o(rdata_b), .cfg_req_o(req_b), .cfg_write_o(cwr_b),
    .cfg_bus_o(cbus_b), .cfg_devfn_o(cdevfn_b), .cfg_off_o(coff_b), .cfg_len_o(clen_b),
    .cfg_wdata_o(cwdata_b), .cfg_rdata_i(crdata_b), .dev_present_i(present),
    .dev_hotplug_i(hotplug));

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  typedef struct packed {
    logic        wr;
    logic        sel;
    logic [1:0]  off;
    logic [2:0]  len;
    logic [31:0] wdata;
    logic        ereq;
    logic [7:0]  ebus;
    logic [7:0]  edevfn;
    logic [7:0]  eoff;
    logic [2:0]  elen;
    logic [31:0] ewdata;
    logic [31:0] erdata;
    logic [7:0]  tag;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,2'd2,3'd1,32'h0,        1'b0,8'h0,8'h0,8'h0,3'd0,32'h0,    32'h0000_0000,8'd12}, // R12
    '{1'b1,1'b0,2'd1,3'd4,32'h8000_0800,1'b0,8'h0,8'h0,8'h0,3'd0,32'h0,    32'h0,        8'd1},  // R1
    '{1'b1,1'b0,2'd0,3'd2,32'h8000_0800,1'b0,8'h0,8'h0,8'h0,3'd0,32'h0,    32'h0,        8'd1},  // R1
    '{1'b0,1'b0,2'd0,3'd4,32'h0,        1'b0,8'h0,8'h0,8'h0,3'd0,32'h0,    32'h0000_0000,8'd1},  // R1
    '{1'b0,1'b1,2'd0,3'd4,32'h0,        1'b0,8'h0,8'h0,8'h0,3'd0,32'h0,    32'hffff_ffff,8'd3},  // R3
    '{1'b1,1'b1,2'd0,3'd4,32'h1122_3344,1'b0,8'h0,8'h0,8'h0,3'd0,32'h0,    32'h0,        8'd3},  // R3
    '{1'b1,1'b0,2'd0,3'd4,32'h8000_0804,1'b0,8'h0,8'h0,8'h0,3'd0,32'h0,    32'h0,        8'd1},  // R1
    '{1'b0,1'b0,2'd3,3'd1,32'h0,        1'b0,8'h0,8'h0,8'h0,3'd0,32'h0,    32'h8000_0804,8'd2},  // R2
    '{1'b0,1'b1,2'd0,3'd4,32'h0,        1'b1,8'h0,8'h08,8'h04,3'd4,32'h0,  32'h0,        8'd4},  // R4
    '{1'b0,1'b1,2'd3,3'd1,32'h0,        1'b1,8'h0,8'h08,8'h07,3'd1,32'h0,  32'h0,        8'd10}, // R10
    '{1'b1,1'b1,2'd2,3'd2,32'hdead_beef,1'b1,8'h0,8'h08,8'h06,3'd2,32'h0000_beef,32'h0,  8'd10}, // R10
    '{1'b0,1'b1,2'd0,3'd3,32'h0,        1'b0,8'h0,8'h0,8'h0,3'd0,32'h0,    32'hffff_ffff,8'd9},  // R9
    '{1'b1,1'b1,2'd0,3'd0,32'h1,        1'b0,8'h0,8'h0,8'h0,3'd0,32'h0,    32'h0,        8'd9},  // R9
    '{1'b1,1'b0,2'd0,3'd4,32'h8000_09fd,1'b0,8'h0,8'h0,8'h0,3'd0,32'h0,    32'h0,        8'd1},  // R1
    '{1'b0,1'b1,2'd2,3'd4,32'h0,        1'b1,8'h0,8'h09,8'hff,3'd1,32'h0,  32'h0,        8'd7},  // R7
    '{1'b0,1'b1,2'd0,3'd4,32'h0,        1'b1,8'h0,8'h09,8'hfd,3'd3,32'h0,  32'h0,        8'd7},  // R7
    '{1'b1,1'b0,2'd0,3'd4,32'h8000_1100,1'b0,8'h0,8'h0,8'h0,3'd0,32'h0,    32'h0,        8'd1},  // R1
    '{1'b0,1'b1,2'd0,3'd4,32'h0,        1'b0,8'h0,8'h0,8'h0,3'd0,32'h0,    32'hffff_ffff,8'd6},  // R6
    '{1'b1,1'b1,2'd0,3'd4,32'h55,       1'b0,8'h0,8'h0,8'h0,3'd0,32'h0,    32'h0,        8'd6},  // R6
    '{1'b1,1'b0,2'd0,3'd4,32'h8000_1200,1'b0,8'h0,8'h0,8'h0,3'd0,32'h0,    32'h0,        8'd1},  // R1
    '{1'b0,1'b1,2'd0,3'd4,32'h0,        1'b1,8'h0,8'h12,8'h00,3'd4,32'h0,  32'h0,        8'd6},  // R6
    '{1'b1,1'b0,2'd0,3'd4,32'h8005_0800,1'b0,8'h0,8'h0,8'h0,3'd0,32'h0,    32'h0,        8'd1},  // R1
    '{1'b0,1'b1,2'd0,3'd4,32'h0,        1'b0,8'h0,8'h0,8'h0,3'd0,32'h0,    32'hffff_ffff,8'd5},  // R5
    '{1'b1,1'b0,2'd0,3'd4,32'h8001_0000,1'b0,8'h0,8'h0,8'h0,3'd0,32'h0,    32'h0,        8'd1},  // R1
    '{1'b0,1'b1,2'd0,3'd4,32'h0,        1'b1,8'h01,8'h00,8'h00,3'd4,32'h0, 32'h0,        8'd5},  // R5
    '{1'b1,1'b0,2'd0,3'd4,32'h8000_1000,1'b0,8'h0,8'h0,8'h0,3'd0,32'h0,    32'h0,        8'd1},  // R1
    '{1'b0,1'b1,2'd0,3'd4,32'h0,        1'b0,8'h0,8'h0,8'h0,3'd0,32'h0,    32'hffff_ffff,8'd5},  // R5
    '{1'b1,1'b0,2'd0,3'd4,32'h0000_0800,1'b0,8'h0,8'h0,8'h0,3'd0,32'h0,    32'h0,        8'd1},  // R1
    '{1'b0,1'b1,2'd0,3'd4,32'h0,        1'b0,8'h0,8'h0,8'h0,3'd0,32'h0,    32'hffff_ffff,8'd3},  // R3
    '{1'b0,1'b0,2'd0,3'd4,32'h0,        1'b0,8'h0,8'h0,8'h0,3'd0,32'h0,    32'h0000_0800,8'd2}   // R2
  };

  // drive one access at negedge; request side sampled 1 ns later, response at next negedge
  task automatic drive(logic wr, logic sel, logic [1:0] off, logic [2:0] len, logic [31:0] wd);
    @(negedge clk);
    h_valid = 1'b1; h_write = wr; h_sel = sel; h_off = off; h_len = len; h_wdata = wd;
    #1;
  endtask

  task automatic release_bus();
    @(negedge clk);
    h_valid = 1'b0; h_write = 1'b0;
  endtask

  initial begin
    present = '0;
    hotplug = '0;
    present[9'h008] = 1'b1;
    present[9'h009] = 1'b1;
    present[9'h011] = 1'b1;
    hotplug[9'h011] = 1'b1;
    present[9'h012] = 1'b1;
    present[9'h100] = 1'b1;

    repeat (3) @(negedge clk);
    chk("R12 rvalid in reset", {31'h0, rvalid}, 32'h0);
    chk("R12 req in reset", {31'h0, req}, 32'h0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string t;
      v = VECS[i];
      t = $sformatf("R%0d vec %0d", v.tag, i);
      drive(v.wr, v.sel, v.off, v.len, v.wdata);
      chk({t, " req"}, {31'h0, req}, {31'h0, v.ereq});
      if (v.ereq) begin
        chk({t, " bus"}, {24'h0, cbus}, {24'h0, v.ebus});
        chk({t, " devfn"}, {24'h0, cdevfn}, {24'h0, v.edevfn});
        chk({t, " off"}, {24'h0, coff}, {24'h0, v.eoff});
        chk({t, " len"}, {29'h0, clen}, {29'h0, v.elen});
        chk({t, " dir"}, {31'h0, cwr}, {31'h0, v.wr});
        if (v.wr) chk({t, " wdata"}, cwdata, v.ewdata);
      end
      release_bus();
      chk({t, " rvalid (R8)"}, {31'h0, rvalid}, {31'h0, !v.wr});
      if (!v.wr)
        chk({t, " rdata"}, rdata,
            v.ereq ? (model(v.ebus, v.edevfn, v.eoff) & msk(v.elen)) : v.erdata);
    end

    // R12: reset mid-run clears an enabled selector
    drive(1'b1, 1'b0, 2'd0, 3'd4, 32'h8000_0804);
    release_bus();
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    drive(1'b0, 1'b0, 2'd0, 3'd4, 32'h0);
    release_bus();
    chk("R12 selector after reset", rdata, 32'h0);
    drive(1'b0, 1'b1, 2'd0, 3'd4, 32'h0);
    chk("R12 no request after reset", {31'h0, req}, 32'h0);
    release_bus();
    chk("R12 data read after reset", rdata, 32'hffff_ffff);

    // R11: big-endian instance
    drive(1'b1, 1'b0, 2'd0, 3'd4, 32'h0408_0080);
    release_bus();
    drive(1'b0, 1'b0, 2'd0, 3'd4, 32'h0);
    release_bus();
    chk("R11 be selector readback", rdata_b, 32'h0408_0080);
    drive(1'b0, 1'b1, 2'd0, 3'd2, 32'h0);
    chk("R11 be devfn", {24'h0, cdevfn_b}, 32'h08);
    chk("R11 be off", {24'h0, coff_b}, 32'h04);
    release_bus();
    begin
      logic [31:0] m;
      m = model(8'h0, 8'h08, 8'h04);
      chk("R11 be read data", rdata_b, {16'h0, m[7:0], m[15:8]});
    end
    drive(1'b1, 1'b1, 2'd0, 3'd2, 32'h0000_1234);
    chk("R11 be req", {31'h0, req_b}, 32'h1);
    chk("R11 be write data", cwdata_b, 32'h0000_3412);
    release_bus();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule